// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor request port and a lower-level memory that moves whole blocks. Each request carries an address that is split into a tag, a set index and an offset. The index selects one set. The tags and valid bits of both ways in that set are compared in the same cycle. A hit is the OR of the two way matches, and the word of the matching way is steered to the read-data output. A hit is answered in the cycle in which it is presented.

On a miss, a single recency bit for the set names the victim way. If the victim holds modified data, the whole block is first written to lower memory. The new block is then fetched and installed. After the refill the request is served as a hit. Writes go only to the cache and mark the block dirty. A write miss first allocates the block and then merges the word into it.

The processor holds a request stable until the cache accepts it. Lower memory gets one block per request/ready handshake.

Top module: `cache2w_top`

## Requirements
- R1: The address is split into fields with the default parameters as follows. Bits [31:9] are the tag, bits [8:5] select one of 16 sets, and bits [4:2] select one of eight 32-bit words in a 32-byte block. Bits [1:0] have no effect on which word is read or written.
- R2: A request hits when either way of the indexed set is valid and holds the request tag. Both ways are compared in parallel, and on a hit cpu_ready is high in the same cycle as cpu_req. At most one way matches.
- R3: On a read hit, cpu_rdata is the selected word of the matching way, and it equals the latest value written to that address. An address never written returns the lower-memory content.
- R4: Each set keeps one recency bit that points at the way not most recently used. It is updated on every hit and every fill, and on a miss the way it names is replaced.
- R5: A write hit changes only the cached word and marks the block dirty. It causes no lower-memory transfer, and a dirty block is always also valid.
- R6: When the victim is dirty, the cache first performs a write transfer (mem_we high). This transfer carries the victim's old block address and all eight of its words. The refill follows it.
- R7: When the victim is clean or invalid, the cache performs only the read transfer of the refill, with no write transfer.
- R8: A write miss fetches the block first and then merges the write word into it. The other words of the block keep their memory values.
- R9: Reset invalidates every block and clears every dirty bit, so the first access to any set misses. cpu_ready stays low from a miss until its refill has completed.
- R10: During a transfer, mem_req, mem_we and mem_addr stay stable until mem_ready. mem_addr is always block-aligned, and each handshake moves exactly one block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write word, 0 = read word |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid while cpu_ready is high |
| cpu_ready | output | 1 | Request accepted at this clock edge |
| mem_req | output | 1 | Lower-memory transfer request |
| mem_we | output | 1 | 1 = write-back of a block, 0 = block fetch |
| mem_addr | output | 32 | Block-aligned lower-memory address |
| mem_wdata | output | 256 | Block written back |
| mem_rdata | input | 256 | Block returned by a fetch |
| mem_ready | input | 1 | One-cycle completion of the current transfer |

## Verification
The bench builds the block with its default parameters: 16 sets, two ways and 32-byte blocks of eight words. With these values a sweep over every set and every word is short. Five distinct tags per set are enough to force every replacement order. These include hits after refills, evictions of the less recently used way, clean and dirty victims, and write-miss allocation. A reference model of tags, recency, dirty state and a shadow memory in the bench predicts each hit or miss, each write-back and each returned word.

// File: rtl/cache2w_pkg.sv
// Package: shared types for the two-way cache.
// Assumes: nothing beyond IEEE 1800-2017.
package cache2w_pkg;
    // Miss-handling controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } cstate_t;
endpackage

// File: rtl/cache2w_way.sv
// Module: one way of the cache. Holds valid, dirty, tag and block storage for
// every set, and compares the stored tag of the indexed set with the request.
// Assumes: fill_en and wr_en are never high together; idx is stable while
// either is high.
module cache2w_way #(
    parameter int SETS   = 16,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 23,
    parameter int WORD_W = 32,
    parameter int WORDS  = 8,
    parameter int WSEL_W = 3,
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  cmp_tag,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic              match,
    output logic              way_valid,
    output logic              way_dirty,
    output logic [TAG_W-1:0]  way_tag,
    output logic [LINE_W-1:0] way_line
);
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];

    // State bits: cleared by reset, set by fill, dirtied by write hits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (wr_en) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Tag and block storage: whole block on fill, one word on write hit
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx]  <= cmp_tag;
            line_q[idx] <= fill_line;
        end else if (wr_en) begin
            line_q[idx][wr_sel*WORD_W +: WORD_W] <= wr_data;
        end
    end

    // Read side and tag comparison for the indexed set
    always_comb begin
        way_valid = valid_q[idx];
        way_dirty = dirty_q[idx];
        way_tag   = tag_q[idx];
        way_line  = line_q[idx];
        match     = valid_q[idx] && (tag_q[idx] == cmp_tag);
    end

    assert_dirty_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        way_dirty |-> way_valid);

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !way_valid);
endmodule

// File: rtl/cache2w_lru.sv
// Module: per-set recency bit for a two-way cache. The bit names the way that
// was not most recently touched; it is the replacement victim on a miss.
// Assumes: touch_en is high for one cycle per hit or fill.
module cache2w_lru #(
    parameter int SETS  = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             touch_en,
    input  logic             touch_way,
    output logic             victim
);
    logic [SETS-1:0] lru_q;

    // Point the set's bit away from the way just used
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (touch_en) begin
            lru_q[idx] <= ~touch_way;
        end
    end

    // Victim lookup for the indexed set
    assign victim = lru_q[idx];

    assert_points_away_R4: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (!$stable(idx) || victim != $past(touch_way)));
endmodule

// File: rtl/cache2w_ctrl.sv
// Module: miss controller. Runs write-back (for dirty victims) then refill,
// holding the processor stalled until the refill has landed.
// Assumes: the processor holds cpu_req and its address until cpu_ready;
// mem_ready is a one-cycle pulse ending one transfer.
module cache2w_ctrl
    import cache2w_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cpu_req,
    input  logic    hit,
    input  logic    victim_in,
    input  logic    vdirty,
    input  logic    mem_ready,
    output cstate_t state,
    output logic    vict_way,
    output logic    cpu_ready,
    output logic    mem_req,
    output logic    mem_we,
    output logic    fill_en
);
    cstate_t state_q, state_d;
    logic    vict_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cpu_req && !hit) state_d = vdirty ? ST_WBACK : ST_FILL;
            ST_WBACK: if (mem_ready) state_d = ST_FILL;
            ST_FILL:  if (mem_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and victim latch taken at miss detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vict_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_req && !hit) vict_q <= victim_in;
        end
    end

    // Output decode
    always_comb begin
        state     = state_q;
        vict_way  = (state_q == ST_IDLE) ? victim_in : vict_q;
        cpu_ready = (state_q == ST_IDLE) && cpu_req && hit;
        mem_req   = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_WBACK);
        fill_en   = (state_q == ST_FILL) && mem_ready;
    end

    assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)));

    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !cpu_ready);

    assert_wb_then_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ready) |=> (mem_req && !mem_we));
endmodule

// File: rtl/cache2w_top.sv
// Module: two-way set-associative write-back cache. Parallel tag compare in
// both ways, OR-ed hit, match-steered read mux, per-set recency replacement,
// write-back of dirty victims before refill, allocate on write miss.
// Assumes: one outstanding processor request, held stable until cpu_ready;
// lower memory moves one whole block per mem_req/mem_ready handshake.
module cache2w_top
    import cache2w_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int WORD_W      = 32,
    parameter int BLOCK_BYTES = 32,
    parameter int SETS        = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_req,
    input  logic                          cpu_we,
    input  logic [ADDR_W-1:0]             cpu_addr,
    input  logic [WORD_W-1:0]             cpu_wdata,
    output logic [WORD_W-1:0]             cpu_rdata,
    output logic                          cpu_ready,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [BLOCK_BYTES*8-1:0]      mem_wdata,
    input  logic [BLOCK_BYTES*8-1:0]      mem_rdata,
    input  logic                          mem_ready
);
    localparam int WAYS   = 2;
    localparam int LINE_W = BLOCK_BYTES * 8;
    localparam int OFF_W  = $clog2(BLOCK_BYTES);
    localparam int BSEL_W = $clog2(WORD_W / 8);
    localparam int WORDS  = BLOCK_BYTES / (WORD_W / 8);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    // Address fields
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_word;
    logic [BSEL_W-1:0] unused_bsel;
    assign req_tag     = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx     = cpu_addr[OFF_W +: IDX_W];
    assign req_word    = cpu_addr[BSEL_W +: WSEL_W];
    assign unused_bsel = cpu_addr[BSEL_W-1:0];

    logic [WAYS-1:0]   match, way_valid, way_dirty, way_fill, way_wr;
    logic [TAG_W-1:0]  way_tag  [WAYS];
    logic [LINE_W-1:0] way_line [WAYS];
    logic [WORD_W-1:0] way_word [WAYS];

    logic    hit, vict_way, victim_in, vdirty, fill_en, touch_en, touch_way;
    cstate_t state;

    assign hit = |match;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            // Per-way write strobes and selected word
            assign way_fill[w] = fill_en && (vict_way == w[0]);
            assign way_wr[w]   = cpu_ready && cpu_we && match[w];
            assign way_word[w] = way_line[w][req_word*WORD_W +: WORD_W];

            cache2w_way #(
                .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .WORD_W(WORD_W),
                .WORDS(WORDS), .WSEL_W(WSEL_W), .LINE_W(LINE_W)
            ) u_way (
                .clk(clk), .rst_n(rst_n), .idx(req_idx), .cmp_tag(req_tag),
                .fill_en(way_fill[w]), .fill_line(mem_rdata),
                .wr_en(way_wr[w]), .wr_sel(req_word), .wr_data(cpu_wdata),
                .match(match[w]), .way_valid(way_valid[w]), .way_dirty(way_dirty[w]),
                .way_tag(way_tag[w]), .way_line(way_line[w])
            );
        end
    endgenerate

    // Read mux steered by the way matches
    assign cpu_rdata = match[1] ? way_word[1] : way_word[0];

    // Recency touched by accepted hits and by fills
    assign touch_en  = cpu_ready || fill_en;
    assign touch_way = cpu_ready ? match[1] : vict_way;

    cache2w_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
        .clk(clk), .rst_n(rst_n), .idx(req_idx),
        .touch_en(touch_en), .touch_way(touch_way), .victim(victim_in)
    );

    assign vdirty = way_valid[vict_way] && way_dirty[vict_way];

    cache2w_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .hit(hit),
        .victim_in(victim_in), .vdirty(vdirty), .mem_ready(mem_ready),
        .state(state), .vict_way(vict_way), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .fill_en(fill_en)
    );

    // Lower-memory address and write-back data
    assign mem_addr  = {(mem_we ? way_tag[vict_way] : req_tag), req_idx, {OFF_W{1'b0}}};
    assign mem_wdata = way_line[vict_way];

    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    assert_ready_on_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> (cpu_req && hit && state == ST_IDLE));

    assert_wb_only_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> vdirty);

    assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> $stable(mem_addr));

    assert_fill_then_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (!$stable(cpu_addr) || hit));
endmodule

// File: tb/cache2w_top_tb.sv
// Bench: sweeps every set and word with a reference model of tags, recency,
// dirty bits and a shadow memory, plus a block-level memory responder.
module cache2w_top_tb;
    localparam int LAT = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ready, mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [255:0] mem_wdata;
    logic [255:0] mem_rdata = '0;
    logic         mem_ready = 1'b0;

    int n_chk = 0, n_bad = 0;
    int wb_cnt = 0, fill_cnt = 0, lat_cnt = 0;
    logic [31:0] xfer_addr = '0, last_wb_addr = '0;
    bit done = 0;

    logic [31:0] mem_store [int unsigned];
    logic [31:0] shadow    [int unsigned];

    logic [22:0] rtag   [16][2];
    bit          rval   [16][2];
    bit          rdirty [16][2];
    bit          rlru   [16];

    always #10 clk = ~clk;

    cache2w_top u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return (a * 32'h0001_9E37) ^ 32'hC3C3_0F0F;
    endfunction

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return mem_store.exists(a) ? mem_store[a] : init_word(a);
    endfunction

    function automatic logic [31:0] sh_rd(input logic [31:0] a);
        return shadow.exists(a) ? shadow[a] : init_word(a);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Block-level lower memory with fixed latency
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            lat_cnt   <= 0;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
            lat_cnt   <= 0;
        end else if (mem_req) begin
            if (lat_cnt == 0) xfer_addr <= mem_addr;
            if (lat_cnt == LAT) begin
                chk(mem_addr == xfer_addr && mem_addr[4:0] == 5'd0, "R10", mem_addr, xfer_addr);
                mem_ready <= 1'b1;
                if (mem_we) begin
                    for (int w = 0; w < 8; w++) mem_store[mem_addr + 4*w] = mem_wdata[w*32 +: 32];
                    last_wb_addr = mem_addr;
                    wb_cnt++;
                end else begin
                    for (int w = 0; w < 8; w++) mem_rdata[w*32 +: 32] <= mem_rd(mem_addr + 4*w);
                    fill_cnt++;
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // One processor access, checked against the reference model
    task automatic acc(input bit we, input logic [22:0] t, input int s, input int w,
                       input int boff, input logic [31:0] wd, input string dreq);
        logic [31:0] a, base, rd, vbase;
        bit m0, m1, hit, exp_wb;
        int way, cycles, wb0, f0;
        a    = {t, s[3:0], w[2:0], boff[1:0]};
        base = {a[31:2], 2'b00};
        m0   = rval[s][0] && rtag[s][0] == t;
        m1   = rval[s][1] && rtag[s][1] == t;
        hit  = m0 || m1;
        way  = m1 ? 1 : (m0 ? 0 : int'(rlru[s]));
        exp_wb = !hit && rval[s][way] && rdirty[s][way];
        vbase  = {rtag[s][way], s[3:0], 5'd0};
        wb0 = wb_cnt; f0 = fill_cnt;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cycles = 0;
        #1;
        while (!cpu_ready && cycles < 100) begin
            @(negedge clk); #1; cycles++;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        if (hit) begin
            chk(cycles == 0, "R2", cycles, 0);
            chk(wb_cnt == wb0 && fill_cnt == f0, we ? "R5" : "R2", wb_cnt - wb0 + fill_cnt - f0, 0);
        end else begin
            chk(cycles > 2 * LAT && fill_cnt == f0 + 1, we ? "R8" : "R9", fill_cnt - f0, 1);
            chk(wb_cnt == wb0 + (exp_wb ? 1 : 0), exp_wb ? "R6" : "R7", wb_cnt - wb0, exp_wb);
            if (exp_wb) begin
                chk(last_wb_addr == vbase, "R6", last_wb_addr, vbase);
                for (int k = 0; k < 8; k++)
                    chk(mem_rd(vbase + 4*k) == sh_rd(vbase + 4*k), "R6", mem_rd(vbase + 4*k), sh_rd(vbase + 4*k));
            end
            rtag[s][way] = t; rval[s][way] = 1; rdirty[s][way] = 0;
        end
        rlru[s] = (way == 0);
        if (we) begin
            shadow[base] = wd;
            rdirty[s][way] = 1;
        end else begin
            chk(rd == sh_rd(base), dreq, rd, sh_rd(base));
        end
    endtask

    initial begin
        for (int s = 0; s < 16; s++) begin
            rlru[s] = 0;
            for (int k = 0; k < 2; k++) begin rval[s][k] = 0; rdirty[s][k] = 0; rtag[s][k] = '0; end
        end
        repeat (3) @(negedge clk);
        chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R9", {cpu_ready, mem_req}, 0);
        rst_n = 1'b1;

        // Cold sweep: every set misses once (R9, R7, R3)
        for (int s = 0; s < 16; s++) acc(0, 23'h12, s, s % 8, 0, 0, "R3");
        // Every word of every set hits, byte bits varied (R1, R2)
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 8; w++) acc(0, 23'h12, s, w, w % 4, 0, "R1");
        // Replacement order (R4)
        for (int s = 0; s < 16; s++) begin
            acc(0, 23'h345, s, 1, 0, 0, "R4");
            acc(0, 23'h12,  s, 2, 0, 0, "R4");
            acc(0, 23'h7,   s, 3, 0, 0, "R4");
            acc(0, 23'h345, s, 4, 0, 0, "R4");
            acc(0, 23'h7,   s, 5, 0, 0, "R4");
        end
        // Write hits, read back, then clean and dirty evictions (R5, R7, R6)
        for (int s = 0; s < 16; s++) begin
            for (int w = 0; w < 8; w++) acc(1, 23'h7, s, w, 3, {8'hD0, s[7:0], 8'h00, w[7:0]}, "R5");
            for (int w = 0; w < 8; w++) acc(0, 23'h7, s, w, 0, 0, "R5");
            acc(0, 23'h4000, s, 0, 0, 0, "R7");
            acc(0, 23'h12,   s, 6, 0, 0, "R6");
        end
        // Write miss allocation and merge (R8)
        for (int s = 0; s < 16; s++) begin
            acc(1, 23'h2AA, s, 3, 0, 32'hBEEF_0000 | s, "R8");
            acc(0, 23'h2AA, s, 3, 0, 0, "R8");
            acc(0, 23'h2AA, s, 2, 0, 0, "R8");
            acc(0, 23'h55,  s, 0, 0, 0, "R6");
            acc(0, 23'h66,  s, 0, 0, 0, "R6");
            acc(0, 23'h2AA, s, 3, 0, 0, "R8");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule